// File: doc/BRIEF.md
# Effective Address Generation Unit

This block forms the effective address of a memory operand for a 16-bit machine that has two instruction formats: a one-word short format and a two-word long format. A short instruction adds a signed 8-bit displacement to a base register. The base is either the instruction address register, which already points past the instruction, or one of three index registers. A long instruction uses its full 16-bit address field, adds an index register to it if the tag selects one, and can optionally follow one level of indirection through memory.

The index registers are ordinary memory words at addresses 1, 2 and 3. For that reason the unit reads them through a word-read port with one cycle of latency, and it uses the same port for the indirect fetch. Storage capacity is a parameter of 4096, 8192, 16384 or 32768 words. Every address the unit presents, on the read port or as its result, keeps only the bits inside that capacity. Arithmetic past the top of storage therefore wraps to the bottom. Base values are always treated as unsigned.

A request is a one-cycle `start` pulse carrying the instruction fields and the current instruction address. The result appears on `ea` together with a one-cycle `ea_valid` pulse.

Top module: `ea_unit`

## Requirements
- R1: Short format (`long_fmt`=0) with tag 00: `ea` = (`iar` + sign-extended `disp`) masked to capacity. `ea_valid` rises in the first cycle after the start edge, no memory read is made, and `indirect` is ignored.
- R2: The displacement is sign-extended from `disp[7]` (instruction bit 8), which gives offsets from -128 to +127.
- R3: Short format with tag 01, 10 or 11: the unit reads memory word 1, 2 or 3 respectively, then `ea` = (word + sign-extended `disp`) masked. `ea_valid` rises 3 cycles after start, after exactly one read.
- R4: Long format, direct, tag 00: `ea` = `addr_field` masked. No read is made, `ea_valid` rises 1 cycle after start, and `iar` and `disp` are ignored.
- R5: Long format, direct, nonzero tag: `ea` = (index word + `addr_field`) masked, after one read, 3 cycles after start.
- R6: Long format with `indirect`=1: the direct address from R4 or R5 is masked and read, and the word found there, masked, becomes `ea`. This takes 3 cycles and 1 read with tag 00, and 5 cycles and 2 reads otherwise.
- R7: With capacity 2^AW words, bits AW..15 of `ea` and of `rd_addr` are always 0. Sums wrap modulo 2^AW, and a base whose sign bit is set is used as an unsigned value.
- R8: `ea_valid` is high for exactly one cycle per request. `ea` keeps its value until the next accepted start. After reset `ea`=0, `ea_valid`=0 and `rd_en`=0.
- R9: A `start` that arrives while a request is in progress is ignored and does not change the result of that request.
- R10: Read port: `rd_data` is sampled in the cycle after the cycle in which `rd_en` is high with `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse |
| long_fmt | input | 1 | 1 = two-word instruction |
| tag | input | 2 | Base select: 00 = IAR (short) or none (long), 01/10/11 = index word 1/2/3 |
| indirect | input | 1 | Indirect flag, used in long format only |
| disp | input | 8 | Short-format displacement |
| addr_field | input | 16 | Long-format address word |
| iar | input | 16 | Instruction address register, already pointing past the instruction |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read address, masked to capacity |
| rd_data | input | 16 | Read data, one cycle after rd_en |
| ea | output | 16 | Effective address |
| ea_valid | output | 1 | One-cycle result strobe |

## Verification
The bench targets wraparound in both directions. It adds a displacement of +1 to the top address and -1 to zero, and forms index-plus-field sums that carry past bit 15. A unit that failed to mask or to sign-extend would return addresses outside storage, or addresses off by 256. It loads an index register with its sign bit set. A design that treated the base as signed or kept its high bits would return the wrong address. It counts the reads and cycles for each format, which exposes an index fetch for tag 00 or a missing or duplicated indirect fetch. A start pulse sent during an indirect request checks that a busy unit does not restart and lose the first result.

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int WORDS = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        long_fmt,
  input  logic [1:0]  tag,
  input  logic        indirect,
  input  logic [7:0]  disp,
  input  logic [15:0] addr_field,
  input  logic [15:0] iar,
  output logic        rd_en,
  output logic [15:0] rd_addr,
  input  logic [15:0] rd_data,
  output logic [15:0] ea,
  output logic        ea_valid
);
  localparam int AW = $clog2(WORDS);
  localparam logic [15:0] MASK = 16'((32'd1 << AW) - 32'd1);

  typedef enum logic [2:0] {S_IDLE, S_RDX, S_ADDX, S_RDI, S_GETI, S_DONE} st_t;

  st_t         st;
  logic        use_ind;
  logic [1:0]  tg;
  logic [15:0] off, acc;

  wire         idle  = (st == S_IDLE);
  wire         go    = start && idle;
  wire [15:0]  sdisp = {{8{disp[7]}}, disp};
  wire [15:0]  offv  = long_fmt ? addr_field : sdisp;
  wire         indv  = long_fmt && indirect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      use_ind <= 1'b0;
      tg      <= 2'd0;
      off     <= 16'd0;
      acc     <= 16'd0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          use_ind <= indv;
          tg      <= tag;
          off     <= offv;
          if (tag != 2'd0) begin
            st <= S_RDX;
          end else begin
            acc <= long_fmt ? addr_field : iar + sdisp;
            st  <= indv ? S_RDI : S_DONE;
          end
        end
        S_RDX:  st <= S_ADDX;
        S_ADDX: begin
          acc <= rd_data + off;
          st  <= use_ind ? S_RDI : S_DONE;
        end
        S_RDI:  st <= S_GETI;
        S_GETI: begin
          acc <= rd_data;
          st  <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_en    = (st == S_RDX) || (st == S_RDI);
  assign rd_addr  = (st == S_RDX) ? {14'd0, tg} : (acc & MASK);
  assign ea       = acc & MASK;
  assign ea_valid = (st == S_DONE);

  a_r7_ea_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> ((ea & ~MASK) == 16'd0));

  a_r7_rd_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ((rd_addr & ~MASK) == 16'd0));

  a_r3_index_word: assert property (@(posedge clk) disable iff (!rst_n)
    (go && tag != 2'd0) |=> (rd_en && rd_addr == {14'd0, $past(tag)}));

  a_r1_no_read_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (go && tag == 2'd0 && !indv) |=> (ea_valid && !rd_en));

  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |=> !ea_valid);

  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ea_valid) && !$past(go) && !ea_valid) |-> $stable(ea));
endmodule

// File: tb/ea_unit_test.sv
module ea_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        long_fmt = 1'b0;
  logic [1:0]  tag = 2'd0;
  logic        indirect = 1'b0;
  logic [7:0]  disp = 8'd0;
  logic [15:0] addr_field = 16'd0;
  logic [15:0] iar = 16'd0;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [15:0] rd_data = 16'd0;
  logic [15:0] ea;
  logic        ea_valid;

  int checks = 0;
  int errors = 0;
  int nreads = 0;
  logic [15:0] mem [0:4095];

  always #10 clk = ~clk;

  ea_unit #(.WORDS(4096)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .long_fmt(long_fmt), .tag(tag),
    .indirect(indirect), .disp(disp), .addr_field(addr_field), .iar(iar),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ea(ea), .ea_valid(ea_valid)
  );

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr[11:0]];
      nreads  <= nreads + 1;
    end
  end

  // long, tag, ind, disp, field, iar, expected ea, reads, cycles
  localparam int NV = 13;
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 8'h78, 16'h0000, 16'h0501, 16'h0579, 2'd0, 3'd1}, // R1
    {1'b0, 2'd0, 1'b0, 8'h80, 16'h0000, 16'h0100, 16'h0080, 2'd0, 3'd1}, // R2
    {1'b0, 2'd0, 1'b0, 8'hFF, 16'h0000, 16'h0000, 16'h0FFF, 2'd0, 3'd1}, // R2 R7
    {1'b0, 2'd0, 1'b0, 8'h01, 16'h0000, 16'h0FFF, 16'h0000, 2'd0, 3'd1}, // R7
    {1'b0, 2'd1, 1'b0, 8'hFE, 16'h0000, 16'h0777, 16'h0061, 2'd1, 3'd3}, // R3
    {1'b0, 2'd2, 1'b0, 8'h00, 16'h0000, 16'h0777, 16'h0123, 2'd1, 3'd3}, // R3 R7
    {1'b0, 2'd3, 1'b0, 8'h7F, 16'h0000, 16'h0777, 16'h006F, 2'd1, 3'd3}, // R3 R7
    {1'b1, 2'd0, 1'b0, 8'h55, 16'h1234, 16'h0777, 16'h0234, 2'd0, 3'd1}, // R4 R7
    {1'b1, 2'd1, 1'b0, 8'hAA, 16'h0401, 16'h0777, 16'h0464, 2'd1, 3'd3}, // R5
    {1'b1, 2'd0, 1'b1, 8'h00, 16'h0579, 16'h0777, 16'h0234, 2'd1, 3'd3}, // R6
    {1'b1, 2'd1, 1'b1, 8'h00, 16'h0401, 16'h0777, 16'h0ABC, 2'd2, 3'd5}, // R6
    {1'b1, 2'd2, 1'b1, 8'h00, 16'h10DD, 16'h0777, 16'h0FFF, 2'd2, 3'd5}, // R6 R7
    {1'b0, 2'd0, 1'b1, 8'h10, 16'h0000, 16'h0300, 16'h0310, 2'd0, 3'd1}  // R1
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic lf, input logic [1:0] tg, input logic ind,
                       input logic [7:0] d, input logic [15:0] fld, input logic [15:0] ia);
    @(negedge clk);
    long_fmt = lf; tag = tg; indirect = ind; disp = d; addr_field = fld; iar = ia;
    nreads = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid(output int cyc);
    cyc = 1;
    while (!ea_valid && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL R10 watchdog actual hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] held;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
    mem[1] = 16'h0063;
    mem[2] = 16'hF123;
    mem[3] = 16'h0FF0;
    mem[16'h0464] = 16'h8ABC;
    mem[16'h0579] = 16'h1234;
    mem[16'h0200] = 16'h0FFF;

    repeat (3) @(negedge clk);
    check("R8 reset ea", ea, 16'h0);
    check("R8 reset valid", {15'd0, ea_valid}, 16'h0);
    check("R8 reset rd_en", {15'd0, rd_en}, 16'h0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [64:0] t;
      t = VEC[v];
      issue(t[64], t[63:62], t[61], t[60:53], t[52:37], t[36:21]);
      wait_valid(cyc);
      check($sformatf("R1-R7 vector %0d ea", v), ea, t[20:5]);
      check($sformatf("R10 vector %0d reads", v), 16'(nreads), {14'd0, t[4:3]});
      check($sformatf("R6 vector %0d cycles", v), 16'(cyc), {13'd0, t[2:0]});
      held = ea;
      @(negedge clk);
      check($sformatf("R8 vector %0d pulse", v), {15'd0, ea_valid}, 16'h0);
      check($sformatf("R8 vector %0d hold", v), ea, held);
    end

    // R9: second start during an indirect request is ignored
    issue(1'b1, 2'd1, 1'b1, 8'h00, 16'h0401, 16'h0000);
    start = 1'b1; long_fmt = 1'b0; tag = 2'd0; indirect = 1'b0; iar = 16'h0700; disp = 8'h01;
    @(negedge clk);
    start = 1'b0;
    cyc = 2;
    while (!ea_valid && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
    check("R9 ea unaffected", ea, 16'h0ABC);
    check("R9 latency", 16'(cyc), 16'd5);
    check("R9 reads", 16'(nreads), 16'd2);
    repeat (3) begin
      @(negedge clk);
      check("R9 no extra result", {15'd0, ea_valid}, 16'h0);
    end
    check("R8 held after idle", ea, 16'h0ABC);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule